// File: doc/BRIEF.md
# Single-Wire Bus Slave ROM Command Responder

This block is the slave end of a single-wire, open-drain bus with a pull-up. It carries a fixed 64-bit identity set by a parameter. Bits 7:0 of the identity hold the family code, bits 55:8 the serial number and bits 63:56 the check byte, so sending the identity from bit 0 upward sends the family code first, then the serial number, then the check byte. The block watches a line input that has already been synchronised, and it counts time with a one-microsecond tick input.

When the master holds the line low long enough, the block treats it as a bus reset and answers with a presence pulse. It then takes in an 8-bit ROM command and carries out one of four operations: reading out the identity, matching an address sent by the master, skipping addressing, or taking part in search arbitration one bit at a time. When a command succeeds, the `selected` flag goes high, and a memory-command stage (not part of this block) takes over. When an address does not match, the block goes quiet until the next bus reset.

The only drive the block has onto the bus is a registered pull-down enable, meant for an open-drain pad.

Top module: `ow_rom_responder`

## Requirements
- R1: After the synchronous `rst`, `pull_low`=0, `selected`=0 and `silent`=1. The block does not drive the bus in any slot until it has seen a bus reset.
- R2: A low period of at least 480 us, once it ends, produces a presence pulse. The pulse starts 15 to 60 us after the line rises and lasts 60 to 240 us (the defaults are 20 us and 120 us).
- R3: A command is 8 bits, received least significant bit first. A codeword other than 33h, 55h, CCh or F0h sets `silent`=1, and the block gives no pull-down in the slots that follow.
- R4: After 33h, the block sends its 64 identity bits, bit 0 first. For a 1 it releases the line. For a 0 it holds the line low for 30 us from the master's falling edge, then releases it. After bit 63, `selected`=1.
- R5: After 55h, the block compares 64 received bits, bit 0 first, against its identity. If all 64 are equal, `selected`=1. On any mismatch, `silent`=1 and `selected` stays 0.
- R6: After CCh, `selected`=1 as soon as the eighth command bit has been taken in. `selected` then holds until a bus reset.
- R7: After F0h, for each bit position from 0 to 63 the block sends the identity bit, then its complement, and then reads the master's chosen bit. If the chosen bit is equal to the identity bit for all 64 positions, `selected`=1.
- R8: In a search, a chosen bit that differs from the identity bit sets `silent`=1. No further slot gets a pull-down from the block until a bus reset.
- R9: A bus reset aborts any transaction in progress. It clears `selected` and `silent`, and the block then takes in a new command.
- R10: A low period shorter than 480 us, such as 400 us, gives no presence pulse and leaves `selected` unchanged.
- R11: A received bit is taken as the line level sampled 30 us after the master's falling edge. A 5 us low reads as 1, and a 60 us low reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| line_in | input | 1 | Synchronised bus level (1 = released) |
| pull_low | output | 1 | Pull-down enable for the open-drain pad |
| selected | output | 1 | A ROM command has succeeded; memory stage may proceed |
| silent | output | 1 | Block ignores the bus until the next bus reset |

## Verification
The checks assume that `line_in` is already synchronised to `clk`. They also assume that `us_tick` is a single-cycle pulse and that successive master falling edges are more than 30 us apart, so that every slot window closes before the next slot begins. The bench keeps to these assumptions. It generates a tick every two clock cycles, and it spaces every master slot 70 us apart. It resolves the bus as the wired-AND of the master's drive and `pull_low`, so the block sees its own pull-down on the line, just as it would on a real open-drain net.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;
  typedef enum logic [3:0] {
    ST_WAIT, ST_CMD, ST_READ, ST_MATCH, ST_STRUE, ST_SCOMP, ST_SDIR, ST_SEL, ST_SILENT
  } rom_state_t;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
endpackage

// File: rtl/ow_line_mon.sv
// Registers the line, reports falling edges, and flags a bus reset when the
// line rises after a low period of at least RESET_US microseconds.
module ow_line_mon #(
  parameter int RESET_US = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic line_in,
  output logic fall_o,
  output logic bus_rst_o
);
  localparam int CW = $clog2(RESET_US + 1);

  logic          line_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= 1'b1;
      low_cnt   <= '0;
      fall_o    <= 1'b0;
      bus_rst_o <= 1'b0;
    end else begin
      line_q    <= line_in;
      fall_o    <= line_q & ~line_in;
      bus_rst_o <= ~line_q & line_in & (low_cnt >= CW'(RESET_US));
      if (line_in)
        low_cnt <= '0;
      else if (us_tick && (low_cnt < CW'(RESET_US)))
        low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ow_presence_gen.sv
// After a bus reset: waits WAIT_US, then requests the pull-down for LEN_US.
module ow_presence_gen #(
  parameter int WAIT_US = 20,
  parameter int LEN_US  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic bus_rst,
  output logic drive_o,
  output logic busy_o
);
  localparam int MAXV = (WAIT_US > LEN_US) ? WAIT_US : LEN_US;
  localparam int PW   = $clog2(MAXV + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_DRIVE} phase_t;
  phase_t        phase;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (bus_rst) begin
      phase <= PH_WAIT;
      cnt   <= '0;
    end else if (us_tick) begin
      case (phase)
        PH_WAIT: begin
          if (cnt == PW'(WAIT_US - 1)) begin
            phase <= PH_DRIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DRIVE: begin
          if (cnt == PW'(LEN_US - 1)) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  assign drive_o = (phase == PH_DRIVE);
  assign busy_o  = (phase != PH_IDLE);
endmodule

// File: rtl/ow_bit_slot.sv
// One bit slot per master falling edge. Samples the line SAMPLE_US after the
// edge. When the slot carries a transmitted 0, pulls low until that same point.
module ow_bit_slot #(
  parameter int SAMPLE_US = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic abort,
  input  logic fall,
  input  logic enable,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic line_in,
  output logic drive_o,
  output logic done_o,
  output logic rx_o
);
  localparam int SW = $clog2(SAMPLE_US + 1);

  logic          act;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      act     <= 1'b0;
      cnt     <= '0;
      drive_o <= 1'b0;
      done_o  <= 1'b0;
      rx_o    <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (!act) begin
        if (fall && enable) begin
          act     <= 1'b1;
          cnt     <= '0;
          drive_o <= tx_en & ~tx_bit;
        end
      end else if (us_tick) begin
        if (cnt == SW'(SAMPLE_US - 1)) begin
          act     <= 1'b0;
          drive_o <= 1'b0;
          done_o  <= 1'b1;
          rx_o    <= line_in;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ow_rom_fsm.sv
// ROM command sequencer: command capture, read-out, match, search, selection.
module ow_rom_fsm
  import ow_rom_pkg::*;
#(
  parameter int                 ID_BITS = 64,
  parameter logic [ID_BITS-1:0] ROM_ID  = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_rst,
  input  logic done,
  input  logic rx,
  output logic listen_o,
  output logic tx_en_o,
  output logic tx_bit_o,
  output logic selected_o,
  output logic silent_o
);
  localparam int IW = $clog2(ID_BITS);

  rom_state_t    state;
  logic [IW-1:0] idx;
  logic [7:0]    cmd, cmd_n;
  logic          last_bit, id_bit;

  always_comb begin
    cmd_n    = {rx, cmd[7:1]};
    last_bit = (idx == IW'(ID_BITS - 1));
    id_bit   = ROM_ID[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      idx   <= '0;
      cmd   <= '0;
    end else if (bus_rst) begin
      state <= ST_CMD;
      idx   <= '0;
    end else if (done) begin
      case (state)
        ST_CMD: begin
          cmd <= cmd_n;
          if (idx == IW'(7)) begin
            idx <= '0;
            case (cmd_n)
              CMD_READ:   state <= ST_READ;
              CMD_MATCH:  state <= ST_MATCH;
              CMD_SKIP:   state <= ST_SEL;
              CMD_SEARCH: state <= ST_STRUE;
              default:    state <= ST_SILENT;
            endcase
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_READ: begin
          if (last_bit) state <= ST_SEL;
          else          idx   <= idx + 1'b1;
        end
        ST_MATCH: begin
          if (rx != id_bit)  state <= ST_SILENT;
          else if (last_bit) state <= ST_SEL;
          else               idx   <= idx + 1'b1;
        end
        ST_STRUE: state <= ST_SCOMP;
        ST_SCOMP: state <= ST_SDIR;
        ST_SDIR: begin
          if (rx != id_bit)  state <= ST_SILENT;
          else if (last_bit) state <= ST_SEL;
          else begin
            state <= ST_STRUE;
            idx   <= idx + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    listen_o   = (state == ST_CMD)   || (state == ST_READ)  || (state == ST_MATCH) ||
                 (state == ST_STRUE) || (state == ST_SCOMP) || (state == ST_SDIR);
    tx_en_o    = (state == ST_READ)  || (state == ST_STRUE) || (state == ST_SCOMP);
    tx_bit_o   = (state == ST_SCOMP) ? ~id_bit : id_bit;
    selected_o = (state == ST_SEL);
    silent_o   = (state == ST_SILENT) || (state == ST_WAIT);
  end
endmodule

// File: rtl/ow_rom_responder.sv
module ow_rom_responder #(
  parameter int                 ID_BITS      = 64,
  parameter logic [ID_BITS-1:0] ROM_ID       = 64'h5C00000A1B2C3D14,
  parameter int                 RESET_US     = 480,
  parameter int                 PRES_WAIT_US = 20,
  parameter int                 PRES_LEN_US  = 120,
  parameter int                 SAMPLE_US    = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic us_tick,
  input  logic line_in,
  output logic pull_low,
  output logic selected,
  output logic silent
);
  logic fall, bus_rst;
  logic pres_drive, pres_busy;
  logic slot_drive, slot_done, slot_rx;
  logic listen, tx_en, tx_bit;

  ow_line_mon #(.RESET_US(RESET_US)) u_mon (
    .clk(clk), .rst(rst), .us_tick(us_tick), .line_in(line_in),
    .fall_o(fall), .bus_rst_o(bus_rst)
  );

  ow_presence_gen #(.WAIT_US(PRES_WAIT_US), .LEN_US(PRES_LEN_US)) u_pres (
    .clk(clk), .rst(rst), .us_tick(us_tick), .bus_rst(bus_rst),
    .drive_o(pres_drive), .busy_o(pres_busy)
  );

  ow_bit_slot #(.SAMPLE_US(SAMPLE_US)) u_slot (
    .clk(clk), .rst(rst), .us_tick(us_tick), .abort(bus_rst),
    .fall(fall), .enable(listen & ~pres_busy),
    .tx_en(tx_en), .tx_bit(tx_bit), .line_in(line_in),
    .drive_o(slot_drive), .done_o(slot_done), .rx_o(slot_rx)
  );

  ow_rom_fsm #(.ID_BITS(ID_BITS), .ROM_ID(ROM_ID)) u_fsm (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .done(slot_done), .rx(slot_rx),
    .listen_o(listen), .tx_en_o(tx_en), .tx_bit_o(tx_bit),
    .selected_o(selected), .silent_o(silent)
  );

  always_ff @(posedge clk) begin
    if (rst) pull_low <= 1'b0;
    else     pull_low <= pres_drive | slot_drive;
  end
endmodule

// File: rtl/ow_rom_chk.sv
module ow_rom_chk #(
  parameter int PULL_MAX_US = 240
) (
  input logic clk,
  input logic rst,
  input logic us_tick,
  input logic pull_low,
  input logic selected,
  input logic silent,
  input logic bus_rst
);
  logic [9:0] run;

  always_ff @(posedge clk) begin
    if (rst || !pull_low) run <= '0;
    else if (us_tick && run != 10'h3FF) run <= run + 1'b1;
  end

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(selected && silent));

  p_quiet_silent_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(silent) && silent) |-> !pull_low);

  p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(selected) && !$past(bus_rst)) |-> selected);

  p_rst_clears_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rst |=> (!selected && !silent));

  p_pull_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run <= 10'(PULL_MAX_US));
endmodule

bind ow_rom_responder ow_rom_chk u_chk (
  .clk(clk), .rst(rst), .us_tick(us_tick), .pull_low(pull_low),
  .selected(selected), .silent(silent), .bus_rst(bus_rst)
);

// File: tb/ow_rom_responder_tb_top.sv
module ow_rom_responder_tb_top;
  localparam int          TD = 2;
  localparam logic [63:0] ID = 64'h5C00000A1B2C3D14;

  typedef struct packed {
    logic [7:0] code;
    logic       sel;
    logic       sil;
  } vec_t;

  localparam vec_t TAB [6] = '{
    '{8'hCC, 1'b1, 1'b0},
    '{8'h00, 1'b0, 1'b1},
    '{8'hCC, 1'b1, 1'b0},
    '{8'hFF, 1'b0, 1'b1},
    '{8'hC3, 1'b0, 1'b1},
    '{8'h5A, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, us_tick = 1'b0, master_low = 1'b0;
  logic pull_low, selected, silent;
  wire  line_in = ~(master_low | pull_low);
  int   div = 0, checks = 0, fails = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (div == TD - 1) begin div <= 0; us_tick <= 1'b1; end
    else begin div <= div + 1; us_tick <= 1'b0; end
  end

  ow_rom_responder #(.ROM_ID(ID)) dut_i (
    .clk(clk), .rst(rst), .us_tick(us_tick), .line_in(line_in),
    .pull_low(pull_low), .selected(selected), .silent(silent)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_us(int n);
    repeat (n * TD) @(negedge clk);
  endtask

  task automatic bus_reset(int low_us, bit expect_pres);
    int first = -1, len = 0;
    @(negedge clk) master_low = 1'b1;
    wait_us(low_us);
    master_low = 1'b0;
    for (int i = 0; i < 300 * TD; i++) begin
      @(negedge clk);
      if (pull_low) begin
        if (first < 0) first = i;
        len++;
      end
    end
    if (expect_pres) begin
      check("R2 presence start", 64'(first >= 15 * TD && first <= 60 * TD), 1);
      check("R2 presence length", 64'(len >= 60 * TD && len <= 240 * TD), 1);
    end else begin
      check("R10 no presence after short low", 64'(len), 0);
    end
  endtask

  task automatic write_bit(bit b);
    @(negedge clk) master_low = 1'b1;
    wait_us(b ? 5 : 60);
    master_low = 1'b0;
    wait_us(b ? 65 : 10);
  endtask

  task automatic read_bit(output bit b, output bit rel);
    @(negedge clk) master_low = 1'b1;
    wait_us(2);
    master_low = 1'b0;
    wait_us(13);
    b = line_in;
    wait_us(30);
    rel = line_in;
    wait_us(25);
  endtask

  task automatic write_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    bit b, r;
    for (int i = 0; i < 8; i++) begin
      read_bit(b, r);
      v[i] = b;
    end
  endtask

  initial begin
    logic [63:0] got, gotc, sent;
    logic [7:0]  byt;
    bit b, c, r;
    int not_rel;

    repeat (5) @(negedge clk);
    check("R1 pull_low after rst", 64'(pull_low), 0);
    check("R1 selected after rst", 64'(selected), 0);
    check("R1 silent after rst", 64'(silent), 1);
    rst = 1'b0;
    wait_us(5);
    read_byte(byt);
    check("R1 no drive before bus reset", 64'(byt), 64'hFF);

    // table of command codes and expected flags (R6 skip, R3 unknown, R11 decode)
    for (int i = 0; i < 6; i++) begin
      bus_reset(500, 1);
      write_byte(TAB[i].code);
      wait_us(5);
      check("R6/R3 table selected", 64'(selected), 64'(TAB[i].sel));
      check("R3 R11 table silent", 64'(silent), 64'(TAB[i].sil));
    end
    read_byte(byt);
    check("R3 no response after unknown code", 64'(byt), 64'hFF);

    // R4 read out identity
    bus_reset(500, 1);
    write_byte(8'h33);
    not_rel = 0;
    for (int i = 0; i < 64; i++) begin
      read_bit(b, r);
      got[i] = b;
      if (!r) not_rel++;
    end
    check("R4 identity bits", got, ID);
    check("R4 line released after 30us", 64'(not_rel), 0);
    check("R4 selected after read", 64'(selected), 1);

    // R5 match with correct address
    bus_reset(500, 1);
    write_byte(8'h55);
    for (int i = 0; i < 64; i++) write_bit(ID[i]);
    check("R5 match selects", 64'(selected), 1);

    // R5 match with bit 40 wrong
    bus_reset(500, 1);
    write_byte(8'h55);
    sent = ID ^ (64'd1 << 40);
    for (int i = 0; i < 64; i++) write_bit(sent[i]);
    check("R5 mismatch not selected", 64'(selected), 0);
    check("R5 mismatch silent", 64'(silent), 1);
    read_byte(byt);
    check("R5 no response after mismatch", 64'(byt), 64'hFF);

    // R7 full search pass following own identity
    bus_reset(500, 1);
    write_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(b, r);
      read_bit(c, r);
      got[i] = b;
      gotc[i] = c;
      write_bit(ID[i]);
    end
    check("R7 search true bits", got, ID);
    check("R7 search complement bits", gotc, ~ID);
    check("R7 search selects", 64'(selected), 1);

    // R8 search diverges at bit 10
    bus_reset(500, 1);
    write_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      read_bit(b, r);
      read_bit(c, r);
      write_bit(i == 10 ? ~ID[i] : ID[i]);
    end
    check("R8 search drop-out silent", 64'(silent), 1);
    read_bit(b, r);
    read_bit(c, r);
    check("R8 no response after drop-out", 64'({b, c}), 64'h3);

    // R9 reset aborts a read in progress
    bus_reset(500, 1);
    write_byte(8'h33);
    for (int i = 0; i < 20; i++) read_bit(b, r);
    bus_reset(500, 1);
    check("R9 abort clears selected", 64'(selected), 0);
    check("R9 abort clears silent", 64'(silent), 0);
    write_byte(8'hCC);
    wait_us(5);
    check("R9 new command after abort", 64'(selected), 1);

    // R10 short low while selected
    bus_reset(400, 0);
    check("R10 short low keeps selected", 64'(selected), 1);
    bus_reset(500, 1);
    check("R9 reset deselects", 64'(selected), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule